// File: doc/BRIEF.md
# Frame-Counted SPI Transfer Sequencer

This block is the master-side engine of an SPI controller. Once its enable bit is set it takes words from a show-ahead transmit FIFO and sends each one as a frame of a programmed bit length. Frames go out MSB first in clock mode 0: SCLK idles low, MOSI changes after a falling edge and MISO is sampled on a rising edge. The bits received in each frame are pushed into a receive FIFO, with the data in the low bits of the word.

Frames are grouped into bursts. The length of a burst is set by a 16-bit frame count that is taken from the control word each time that word is written. The active-low chip select is driven by the block. A control bit selects one of two modes: chip select stays low for the whole burst, or it is released after every frame. At the end of a burst the block raises chip select, reloads the count, pulses a completion event and sets a sticky done flag. That flag clears again at the next frame start.

The block also holds the control word, the frame size and the clock divider. It rejects frame sizes outside 1..32 and any frame-size write made while it is enabled. Register decode and interrupt masking are handled by neighbouring logic.

Top module: `spi_frame_seq`

## Requirements
- R1: After reset, cfg_ctrl is 0x80000102 (bit 31 set, bit 8 set so the count is 1, enable bit 0 clear), cfg_fsize is 4, cfg_div is 7, cs_n is high, sclk is low, and active and st_done are low.
- R2: A frame starts only when ctrl bit 0 is 1, tx_empty is low and the remaining frame count is nonzero. Each frame gives exactly one single-cycle tx_pop pulse, in the cycle after the head word is taken.
- R3: Each frame shifts the low cfg_fsize bits of the word out on mosi, MSB first. mosi changes only after a falling sclk edge, and miso is sampled at each rising edge. rx_push carries the received bits in the low cfg_fsize bits of rx_data, with the upper bits zero.
- R4: Each sclk half period lasts (cfg_div+1)*2 clock cycles, so a full bit period is 4*(cfg_div+1) cycles. sclk is low whenever cs_n is high.
- R5: Every control write loads the frame count from ctrl bits [23:8]. The count decreases by one per frame, and a burst ends after that many frames. The count then reloads from ctrl[23:8], so the remaining words form a new burst.
- R6: With ctrl bit 26 at 1, cs_n stays low across the burst and rises once, at its end. With bit 26 at 0, cs_n rises after every frame.
- R7: frame_start pulses at each frame start with cs_n low and st_done clear. At burst end, burst_done pulses for one cycle, with st_done set and cs_n high.
- R8: active is high from the first chip-select assertion of a burst until that burst completes. While active is low, cs_n is high.
- R9: A frame-size write takes effect only while ctrl bit 0 is 0 and the value is in 1..32. Any other frame-size write leaves cfg_fsize unchanged.
- R10: A control write with bit 31 set restores the R1 values: control 0x80000102, frame size 4, divider 7, count 1, disabled, st_done clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write value |
| fsize_we | input | 1 | Frame-size write strobe |
| fsize_wdata | input | FS_W | Frame-size write value |
| div_we | input | 1 | Clock-divider write strobe |
| div_wdata | input | DIV_W | Clock-divider write value |
| cfg_ctrl | output | 32 | Current control word |
| cfg_fsize | output | FS_W | Current frame size in bits |
| cfg_div | output | DIV_W | Current clock-divider value |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | DATA_W | Transmit FIFO head word (show-ahead) |
| tx_pop | output | 1 | Transmit FIFO pop pulse |
| rx_push | output | 1 | Receive FIFO push pulse |
| rx_data | output | DATA_W | Received frame, right-aligned |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | 1 | Active-low chip select |
| frame_start | output | 1 | Frame start event |
| burst_done | output | 1 | Burst completion event |
| st_done | output | 1 | Sticky transmit-done / receive-ready flag |
| active | output | 1 | Burst in progress |

## Verification
Some properties are checked on every cycle. sclk stays low while chip select is high, and chip select is high whenever no burst is active. The frame-size field stays in range and does not change under a write made while enabled. In hold mode, chip select rises only at burst end or on a control write. Event pulses agree with the chip-select, active and done state. Other behaviour only shows up in the bench's scenarios: bit order and data integrity through a modelled slave, the measured SCLK period for two divider values, frame counts per burst including the reload into a second burst, the number of chip-select releases per burst in each mode, stalls when disabled or when the count is zero, and the soft reset.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    localparam logic [31:0] CTRL_RST_VAL = 32'h8000_0102;
    localparam int EN_BIT   = 0;
    localparam int HOLD_BIT = 26;
    localparam int SRST_BIT = 31;
    localparam int CNT_LSB  = 8;
    localparam int CNT_MSB  = 23;
    localparam int CNT_W    = CNT_MSB - CNT_LSB + 1;
    localparam int FS_RST   = 4;
    localparam int DIV_RST  = 7;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SHIFT = 2'd1,
        SQ_GAP   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/spi_seq_cfg.sv
module spi_seq_cfg
    import spi_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FS_W   = 6,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [31:0]      ctrl_wdata,
    input  logic             fsize_we,
    input  logic [FS_W-1:0]  fsize_wdata,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    output logic [31:0]      ctrl_q,
    output logic [FS_W-1:0]  fsize_q,
    output logic [DIV_W-1:0] div_q
);
    typedef struct packed {
        logic [31:0]      ctrl;
        logic [FS_W-1:0]  fs;
        logic [DIV_W-1:0] div;
    } cfg_t;

    localparam cfg_t CFG_RST = '{ctrl: CTRL_RST_VAL, fs: FS_W'(FS_RST), div: DIV_W'(DIV_RST)};

    cfg_t cfg_d, cfg_q;
    logic fs_ok;

    assign fs_ok = (fsize_wdata != '0) && (fsize_wdata <= FS_W'(DATA_W));

    always_comb begin
        cfg_d = cfg_q;
        if (div_we) begin
            cfg_d.div = div_wdata;
        end
        // frame size is frozen while enabled and range-checked
        if (fsize_we && !cfg_q.ctrl[EN_BIT] && fs_ok) begin
            cfg_d.fs = fsize_wdata;
        end
        if (ctrl_we) begin
            if (ctrl_wdata[SRST_BIT]) begin
                cfg_d = CFG_RST;
            end else begin
                cfg_d.ctrl = ctrl_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ctrl_q  = cfg_q.ctrl;
    assign fsize_q = cfg_q.fs;
    assign div_q   = cfg_q.div;
endmodule

// File: rtl/spi_seq_clkdiv.sv
module spi_seq_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    // half period = (div+1)*2 cycles, so terminal count = 2*div+1
    logic [DIV_W:0] cnt_d, cnt_q;
    logic [DIV_W:0] term;

    assign term = {div, 1'b1};
    assign tick = (cnt_q >= term);

    always_comb begin
        if (restart || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
    import spi_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FS_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              hold,
    input  logic [FS_W-1:0]   fsize,
    input  logic              tick,
    input  logic              clr,
    input  logic              soft_rst,
    input  logic [CNT_W-1:0]  reload_now,
    input  logic [CNT_W-1:0]  reload_cfg,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              miso,
    output logic              restart,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              frame_start,
    output logic              burst_done,
    output logic              st_done,
    output logic              active
);
    typedef struct packed {
        seq_state_e        st;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rx;
        logic [FS_W-1:0]   bits;
        logic [CNT_W-1:0]  cnt;
        logic              sclk;
        logic              cs_n;
        logic              active;
        logic              done;
        logic              pop;
        logic              push;
        logic              fstart;
        logic              bdone;
    } eng_t;

    localparam eng_t ENG_RST = '{st: SQ_IDLE, sh: '0, rx: '0, bits: '0,
                                 cnt: CNT_W'(1), sclk: 1'b0, cs_n: 1'b1,
                                 active: 1'b0, done: 1'b0, pop: 1'b0,
                                 push: 1'b0, fstart: 1'b0, bdone: 1'b0};

    eng_t e_d, e_q;
    logic [FS_W:0] sh_amt;

    // left-justify the frame so its MSB sits at the top of the shifter
    assign sh_amt = (FS_W+1)'(DATA_W) - {1'b0, fsize};

    always_comb begin
        e_d        = e_q;
        e_d.pop    = 1'b0;
        e_d.push   = 1'b0;
        e_d.fstart = 1'b0;
        e_d.bdone  = 1'b0;
        restart    = 1'b0;
        case (e_q.st)
            SQ_IDLE: begin
                if (en && !tx_empty && (e_q.cnt != '0)) begin
                    e_d.st     = SQ_SHIFT;
                    e_d.sh     = tx_data << sh_amt;
                    e_d.rx     = '0;
                    e_d.bits   = fsize;
                    e_d.sclk   = 1'b0;
                    e_d.cs_n   = 1'b0;
                    e_d.active = 1'b1;
                    e_d.done   = 1'b0;
                    e_d.pop    = 1'b1;
                    e_d.fstart = 1'b1;
                    restart    = 1'b1;
                end
            end
            SQ_SHIFT: begin
                if (tick) begin
                    if (!e_q.sclk) begin
                        e_d.sclk = 1'b1;
                        e_d.rx   = {e_q.rx[DATA_W-2:0], miso};
                    end else begin
                        e_d.sclk = 1'b0;
                        e_d.sh   = e_q.sh << 1;
                        e_d.bits = e_q.bits - 1'b1;
                        if (e_q.bits == FS_W'(1)) begin
                            e_d.push = 1'b1;
                            e_d.cnt  = e_q.cnt - 1'b1;
                            if (e_q.cnt == CNT_W'(1)) begin
                                e_d.st     = SQ_IDLE;
                                e_d.cs_n   = 1'b1;
                                e_d.active = 1'b0;
                                e_d.done   = 1'b1;
                                e_d.bdone  = 1'b1;
                                e_d.cnt    = reload_cfg;
                            end else if (!hold) begin
                                e_d.st   = SQ_GAP;
                                e_d.cs_n = 1'b1;
                            end else begin
                                e_d.st = SQ_IDLE;
                            end
                        end
                    end
                end
            end
            SQ_GAP: begin
                if (tick) begin
                    e_d.st = SQ_IDLE;
                end
            end
            default: e_d.st = SQ_IDLE;
        endcase
        // a control write abandons any frame and reloads the count
        if (clr) begin
            e_d.st     = SQ_IDLE;
            e_d.sclk   = 1'b0;
            e_d.cs_n   = 1'b1;
            e_d.active = 1'b0;
            e_d.cnt    = reload_now;
            e_d.pop    = 1'b0;
            e_d.push   = 1'b0;
            e_d.fstart = 1'b0;
            e_d.bdone  = 1'b0;
            restart    = 1'b1;
            if (soft_rst) begin
                e_d.done = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= ENG_RST;
        end else begin
            e_q <= e_d;
        end
    end

    assign tx_pop      = e_q.pop;
    assign rx_push     = e_q.push;
    assign rx_data     = e_q.rx;
    assign sclk        = e_q.sclk;
    assign mosi        = e_q.sh[DATA_W-1];
    assign cs_n        = e_q.cs_n;
    assign frame_start = e_q.fstart;
    assign burst_done  = e_q.bdone;
    assign st_done     = e_q.done;
    assign active      = e_q.active;
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
    import spi_seq_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int DIV_W  = 8,
    localparam int FS_W   = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [31:0]       ctrl_wdata,
    input  logic              fsize_we,
    input  logic [FS_W-1:0]   fsize_wdata,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    output logic [31:0]       cfg_ctrl,
    output logic [FS_W-1:0]   cfg_fsize,
    output logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n,
    output logic              frame_start,
    output logic              burst_done,
    output logic              st_done,
    output logic              active
);
    logic [31:0] ctrl_eff;
    logic        restart;
    logic        tick;

    // value the control word will hold after this write
    assign ctrl_eff = ctrl_wdata[SRST_BIT] ? CTRL_RST_VAL : ctrl_wdata;

    spi_seq_cfg #(.DATA_W(DATA_W), .FS_W(FS_W), .DIV_W(DIV_W)) cfg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .ctrl_wdata  (ctrl_wdata),
        .fsize_we    (fsize_we),
        .fsize_wdata (fsize_wdata),
        .div_we      (div_we),
        .div_wdata   (div_wdata),
        .ctrl_q      (cfg_ctrl),
        .fsize_q     (cfg_fsize),
        .div_q       (cfg_div)
    );

    spi_seq_clkdiv #(.DIV_W(DIV_W)) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div     (cfg_div),
        .tick    (tick)
    );

    spi_seq_engine #(.DATA_W(DATA_W), .FS_W(FS_W)) eng_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (cfg_ctrl[EN_BIT]),
        .hold        (cfg_ctrl[HOLD_BIT]),
        .fsize       (cfg_fsize),
        .tick        (tick),
        .clr         (ctrl_we),
        .soft_rst    (ctrl_wdata[SRST_BIT]),
        .reload_now  (ctrl_eff[CNT_MSB:CNT_LSB]),
        .reload_cfg  (cfg_ctrl[CNT_MSB:CNT_LSB]),
        .tx_empty    (tx_empty),
        .tx_data     (tx_data),
        .miso        (miso),
        .restart     (restart),
        .tx_pop      (tx_pop),
        .rx_push     (rx_push),
        .rx_data     (rx_data),
        .sclk        (sclk),
        .mosi        (mosi),
        .cs_n        (cs_n),
        .frame_start (frame_start),
        .burst_done  (burst_done),
        .st_done     (st_done),
        .active      (active)
    );
endmodule

// File: rtl/spi_frame_seq_chk.sv
module spi_frame_seq_chk #(
    parameter int FS_W   = 6,
    parameter int DATA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctrl_we,
    input logic            fsize_we,
    input logic [31:0]     cfg_ctrl,
    input logic [FS_W-1:0] cfg_fsize,
    input logic            tx_pop,
    input logic            sclk,
    input logic            cs_n,
    input logic            frame_start,
    input logic            burst_done,
    input logic            st_done,
    input logic            active
);
    p_pop_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !tx_pop);

    p_sclk_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_hold_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n) && $past(cfg_ctrl[26]) && !$past(ctrl_we)) |-> burst_done);

    p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (!cs_n && active && !st_done));

    p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> (cs_n && st_done && !active));

    p_active_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> cs_n);

    p_fsize_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fsize != '0) && (cfg_fsize <= FS_W'(DATA_W)));

    p_fsize_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fsize_we && cfg_ctrl[0] && !ctrl_we) |=> $stable(cfg_fsize));
endmodule

bind spi_frame_seq spi_frame_seq_chk #(.FS_W(FS_W), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (ctrl_we),
    .fsize_we    (fsize_we),
    .cfg_ctrl    (cfg_ctrl),
    .cfg_fsize   (cfg_fsize),
    .tx_pop      (tx_pop),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .frame_start (frame_start),
    .burst_done  (burst_done),
    .st_done     (st_done),
    .active      (active)
);

// File: tb/spi_frame_seq_tb_top.sv
`timescale 1ns/1ps
module spi_frame_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        fsize_we = 1'b0;
    logic [5:0]  fsize_wdata = '0;
    logic        div_we = 1'b0;
    logic [7:0]  div_wdata = '0;
    logic [31:0] cfg_ctrl;
    logic [5:0]  cfg_fsize;
    logic [7:0]  cfg_div;
    logic        tx_empty_b = 1'b1;
    logic [31:0] tx_data_b = '0;
    logic        tx_pop, rx_push, sclk, mosi, miso_b, cs_n;
    logic [31:0] rx_data;
    logic        frame_start, burst_done, st_done, active;

    always #10 clk = ~clk;

    spi_frame_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .fsize_we(fsize_we), .fsize_wdata(fsize_wdata),
        .div_we(div_we), .div_wdata(div_wdata),
        .cfg_ctrl(cfg_ctrl), .cfg_fsize(cfg_fsize), .cfg_div(cfg_div),
        .tx_empty(tx_empty_b), .tx_data(tx_data_b), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data),
        .sclk(sclk), .mosi(mosi), .miso(miso_b), .cs_n(cs_n),
        .frame_start(frame_start), .burst_done(burst_done),
        .st_done(st_done), .active(active)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [31:0] txq[$];
    logic [31:0] replyq[$];
    logic [31:0] exp_tx[$];
    logic [31:0] exp_rx[$];
    int fs_b = 4;
    int div_b = 7;
    bit en_b = 0;
    bit hold_b = 0;
    int burst_exp = 1;
    int frames_in_burst = 0;
    int cs_rises = 0;
    int pops = 0;
    int sent = 0;
    int cyc = 0;
    int last_rise = 0;
    int rises_in_frame = 0;
    logic cs_prev = 1'b1;
    logic sclk_prev = 1'b0;
    logic [31:0] cap = '0;
    logic [31:0] cur_reply = '0;
    int bitidx = 0;

    function automatic logic [31:0] fmask(int fs);
        return (fs >= 32) ? 32'hFFFF_FFFF : ((32'h1 << fs) - 32'h1);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // transmit FIFO model (show-ahead)
    always @(posedge clk) begin
        cyc <= cyc + 1;
        tx_empty_b <= (txq.size() == 0);
        tx_data_b  <= (txq.size() != 0) ? txq[0] : 32'h0;
    end

    // slave model: samples mosi on rising, advances miso on falling
    always @(posedge sclk) cap = {cap[30:0], mosi};
    always @(negedge sclk) bitidx = bitidx + 1;
    always_comb miso_b = (bitidx < fs_b) ? cur_reply[fs_b - 1 - bitidx] : 1'b0;

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_pop) begin
                pops++;
                if (txq.size() != 0) void'(txq.pop_front());
            end
            if (cs_n && !cs_prev) cs_rises++;
            if (sclk && !sclk_prev) begin
                if (rises_in_frame > 0)
                    chk((cyc - last_rise) == 4 * (div_b + 1), "R4", "sclk period",
                        32'(cyc - last_rise), 32'(4 * (div_b + 1)));
                last_rise = cyc;
                rises_in_frame++;
            end
            if (frame_start) begin
                chk(!cs_n && active && !st_done, "R7", "frame start state",
                    {29'b0, cs_n, active, st_done}, 32'b010);
                cap = '0;
                bitidx = 0;
                rises_in_frame = 0;
                cur_reply = (replyq.size() != 0) ? replyq.pop_front() : 32'h0;
            end
            if (rx_push) begin
                logic [31:0] et, er;
                et = (exp_tx.size() != 0) ? exp_tx.pop_front() : 32'hDEAD_BEEF;
                er = (exp_rx.size() != 0) ? exp_rx.pop_front() : 32'hDEAD_BEEF;
                chk(rx_data == er, "R3", "rx word", rx_data, er);
                chk((cap & fmask(fs_b)) == et, "R3", "mosi word", cap & fmask(fs_b), et);
                frames_in_burst++;
            end
            if (burst_done) begin
                chk(frames_in_burst == burst_exp, "R5", "frames per burst",
                    32'(frames_in_burst), 32'(burst_exp));
                chk(cs_rises == (hold_b ? 1 : burst_exp), "R6", "cs releases per burst",
                    32'(cs_rises), 32'(hold_b ? 1 : burst_exp));
                chk(st_done && !active && cs_n, "R8", "burst end state",
                    {29'b0, st_done, active, cs_n}, 32'b101);
                frames_in_burst = 0;
                cs_rises = 0;
            end
            cs_prev = cs_n;
            sclk_prev = sclk;
        end
    end

    task automatic wr_ctrl(logic [31:0] v);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        if (v[31]) begin
            en_b = 0; hold_b = 0; fs_b = 4; div_b = 7; burst_exp = 1;
        end else begin
            en_b = v[0]; hold_b = v[26]; burst_exp = int'(v[23:8]);
        end
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_fs(int v);
        @(negedge clk);
        fsize_we = 1'b1;
        fsize_wdata = 6'(v);
        if (!en_b && v >= 1 && v <= 32) fs_b = v;
        @(negedge clk);
        fsize_we = 1'b0;
        @(negedge clk);
        chk(cfg_fsize == 6'(fs_b), "R9", "frame size after write", 32'(cfg_fsize), 32'(fs_b));
    endtask

    task automatic wr_div(int v);
        @(negedge clk);
        div_we = 1'b1;
        div_wdata = 8'(v);
        div_b = v;
        @(negedge clk);
        div_we = 1'b0;
    endtask

    task automatic send(logic [31:0] tx, logic [31:0] reply);
        txq.push_back(tx);
        replyq.push_back(reply);
        exp_tx.push_back(tx & fmask(fs_b));
        exp_rx.push_back(reply & fmask(fs_b));
        sent++;
    endtask

    task automatic drain(string req);
        int n = 0;
        while ((exp_rx.size() != 0 || active) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(exp_rx.size() == 0, req, "frames drained", 32'(exp_rx.size()), 32'h0);
        repeat (5) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            summary();
            $finish;
        end
    end

    initial begin
        int p0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_ctrl == 32'h8000_0102, "R1", "ctrl reset", cfg_ctrl, 32'h8000_0102);
        chk(cfg_fsize == 6'd4, "R1", "fsize reset", 32'(cfg_fsize), 32'd4);
        chk(cfg_div == 8'd7, "R1", "div reset", 32'(cfg_div), 32'd7);
        chk(cs_n && !sclk && !active && !st_done, "R1", "pins reset",
            {28'b0, cs_n, sclk, active, st_done}, 32'b1000);

        wr_div(0);
        wr_fs(33);   // R9 out of range, rejected
        wr_fs(0);    // R9 zero, rejected
        wr_fs(8);

        // pulse mode, count 2, four words -> two bursts (R5 reload, R6)
        wr_ctrl((32'd2 << 8) | 32'h1);
        send(32'h0000_00A5, 32'h0000_003C);
        send(32'hFFFF_FF01, 32'h0000_00C3);
        send(32'h0000_0080, 32'h0000_00FF);
        send(32'h1234_567E, 32'h0000_0001);
        drain("R5");

        // hold mode, count 3, frames of 16 bits (R6)
        wr_ctrl(32'h0);
        wr_fs(16);
        wr_ctrl((32'h1 << 26) | (32'd3 << 8) | 32'h1);
        wr_fs(12);   // R9 ignored while enabled
        send(32'h0000_BEEF, 32'h0000_1234);
        send(32'h0000_8001, 32'h0000_F00D);
        send(32'h0000_5AA5, 32'h0000_0F0F);
        drain("R6");

        // disabled: queued word must wait (R2)
        wr_ctrl(32'h0);
        wr_fs(32);
        wr_div(1);
        wr_ctrl(32'd1 << 8);
        p0 = pops;
        send(32'h8765_4321, 32'hC001_D00D);
        repeat (100) @(negedge clk);
        chk(pops == p0 && cs_n, "R2", "no frame while disabled", 32'(pops - p0), 32'h0);
        wr_ctrl((32'd1 << 8) | 32'h1);
        drain("R3");

        // enabled with zero count: no frame (R2, R5)
        wr_ctrl(32'h1);
        p0 = pops;
        send(32'h0F0F_F0F0, 32'h8000_0001);
        repeat (100) @(negedge clk);
        chk(pops == p0 && cs_n, "R2", "no frame with zero count", 32'(pops - p0), 32'h0);
        wr_ctrl((32'd1 << 8) | 32'h1);
        drain("R5");

        chk(pops == sent, "R2", "one pop per frame", 32'(pops), 32'(sent));

        // soft reset (R10)
        wr_ctrl(32'h8000_0000);
        @(negedge clk);
        chk(cfg_ctrl == 32'h8000_0102, "R10", "ctrl after soft reset", cfg_ctrl, 32'h8000_0102);
        chk(cfg_fsize == 6'd4, "R10", "fsize after soft reset", 32'(cfg_fsize), 32'd4);
        chk(cfg_div == 8'd7, "R10", "div after soft reset", 32'(cfg_div), 32'd7);
        chk(cs_n && !active && !st_done, "R10", "state after soft reset",
            {29'b0, cs_n, active, st_done}, 32'b100);

        finished = 1;
        summary();
        $finish;
    end
endmodule